// File: doc/BRIEF.md
# Pad Function Override Multiplexer

This block sits between a chip's peripherals and its general-purpose pads. For every pin it produces four control lines for the analog pad cell: output enable, output value, open-drain select and pull-up enable. The normal behaviour of a pin comes from a 4-bit mode code held in a per-pin register. Alternate output modes take their value from a peripheral. A timer channel that is enabled takes precedence over the serial or trace output offered for the same pin. Each timer channel can be steered to one of two pins.

On top of the per-pin modes sit forced functions that ignore the mode code. A regulator-enable control bit takes over pin A7. An active debugger takes over the debug pins C0, C2, C3 and C4, unless a debug-disable bit hands them back to ordinary use. Software changes the mode codes, the output data and the two control bits through plain write strobes. A full chip reset returns all of them to defined values. The pad controls are combinational functions of these registers and of the live peripheral and debugger signals.

Pin numbering is port × 8 + bit: port A is pins 0–7, port B is pins 8–15 and port C is pins 16–23. Pad controls are listed below as the 4-bit group {oe, out, od, pu}.

Top module: `pad_func_mux`

## Requirements
- R1: A synchronous reset sets every mode code to 0x4 (floating input), clears the output data register, sets the regulator-enable bit and clears the debug-disable bit, so every pin that is not forced reads {0,0,0,0}.
- R2: Mode 0x1 gives a push-pull output of the data bit {1,d,0,0}. Mode 0x5 gives an open-drain output of the data bit {1,d,1,0}. Mode 0x8 gives an input with pull-up {0,0,0,1}. Mode 0x4 gives a floating input {0,0,0,0}.
- R3: Any mode code outside 0x1, 0x4, 0x5, 0x8, 0x9, 0xB and 0xD, including 0x0, gives a floating input {0,0,0,0} with the pad never driven.
- R4: Modes 0x9 (alternate push-pull) and 0xB (push-pull clock for a serial master) give {1,a,0,0}. Mode 0xD (alternate open-drain, external pull only) gives {1,a,1,0}, where a is the alternate value of the pin.
- R5: A pin in an alternate mode that has neither an enabled timer channel nor a valid serial source outputs a = 0.
- R6: When a timer channel is enabled and routed to a pin, its value is that pin's alternate value, whatever the serial source offers. When the channel is disabled, the serial value is used.
- R7: Bit k of tmr_remap picks the pin for timer channel k+1. When the bit is 0 the pins are: channel 1 to A0, channel 2 to A3, channel 3 to A1, channel 4 to A2. When the bit is 1 the pins are B1, B2, B3 and B4 in the same channel order.
- R8: While the regulator-enable bit is set, pin A7 reads {1,reg_en_sig,1,0} whatever its mode code. Once the bit is cleared, A7 follows its mode.
- R9: With dbg_active=1, dbg_swd=0 and debug-disable clear, pins C0, C3 and C4 read {0,0,0,1} and pin C2 reads {1,dbg_tdo,0,0}.
- R10: With dbg_active=1, dbg_swd=1 and debug-disable clear, pin C4 reads {dbg_swdio_oe,dbg_swdio_out,0,0}, and C0, C2 and C3 follow their mode codes.
- R11: With debug-disable set, all four debug pins follow their mode codes whatever the debugger state.
- R12: A mode-code, data or control write takes effect on the clock edge that samples the strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high full chip reset |
| cfg_we | input | 1 | Mode code write strobe |
| cfg_pin | input | 5 | Pin index of the mode write |
| cfg_code | input | 4 | Mode code to write |
| dout_we | input | 1 | Output data write strobe |
| dout_data | input | 24 | New output data, one bit per pin |
| ctrl_we | input | 1 | Control bits write strobe |
| ctrl_regen | input | 1 | New regulator-enable bit |
| ctrl_dbg_dis | input | 1 | New debug-disable bit |
| tmr_ch_out | input | 4 | Timer channel output values |
| tmr_ch_en | input | 4 | Timer channel output enables |
| tmr_remap | input | 4 | Per-channel pin location select |
| ser_out | input | 24 | Serial/trace alternate value per pin |
| ser_valid | input | 24 | A serial/trace source is assigned to the pin |
| reg_en_sig | input | 1 | Regulator enable signal forced onto A7 |
| dbg_active | input | 1 | Debugger interface active |
| dbg_swd | input | 1 | Debugger mode: 0 JTAG, 1 serial wire |
| dbg_tdo | input | 1 | JTAG data out forced onto C2 |
| dbg_swdio_oe | input | 1 | Serial-wire data direction for C4 |
| dbg_swdio_out | input | 1 | Serial-wire data value for C4 |
| pad_oe | output | 24 | Pad output enable |
| pad_out | output | 24 | Pad output value |
| pad_od | output | 24 | Pad open-drain select |
| pad_pu | output | 24 | Pad pull-up enable |

## Verification
Two decisions can fall in the same cycle. The first is the timer-over-serial choice on a pin in an alternate mode. The second is a forced function that replaces a pin's mode, such as a write to the regulator or debug-disable bits while the debugger is active. The vector walk drives an enabled timer channel and a valid serial source with opposite values onto one pin, and judges that the pad carries the timer value. The directed tests then move each timer channel between its two pins to confirm it lands only on the selected one. They also switch the debugger mode and the control bits on pins whose mode codes would give visibly different pad controls, so the source that wins can be read straight from the pad lines.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;

  typedef struct packed {
    logic oe;
    logic out;
    logic od;
    logic pu;
  } pad_ctl_t;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_GPIO_PP = 4'h1;
  localparam logic [MODE_W-1:0] MODE_IN_FLOAT = 4'h4;
  localparam logic [MODE_W-1:0] MODE_GPIO_OD = 4'h5;
  localparam logic [MODE_W-1:0] MODE_IN_PULL = 4'h8;
  localparam logic [MODE_W-1:0] MODE_ALT_PP = 4'h9;
  localparam logic [MODE_W-1:0] MODE_ALT_CLK = 4'hB;
  localparam logic [MODE_W-1:0] MODE_ALT_OD = 4'hD;

  localparam pad_ctl_t PAD_FLOAT = '{oe: 1'b0, out: 1'b0, od: 1'b0, pu: 1'b0};
  localparam pad_ctl_t PAD_PULLED = '{oe: 1'b0, out: 1'b0, od: 1'b0, pu: 1'b1};

  localparam int PORT_A = 0;
  localparam int PORT_B = 1;
  localparam int PORT_C = 2;

  function automatic int pin_of(int port, int bitn, int ppp);
    return port * ppp + bitn;
  endfunction

  // Port A bit used by a timer channel when its remap bit is 0
  function automatic int tmr_home_bit(int ch);
    case (ch)
      0: return 0;
      1: return 3;
      2: return 1;
      default: return 2;
    endcase
  endfunction

  // Port B bit used by a timer channel when its remap bit is 1
  function automatic int tmr_alt_bit(int ch);
    return ch + 1;
  endfunction

endpackage

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
  import pad_mux_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [PIN_W-1:0]               cfg_pin,
  input  logic [MODE_W-1:0]              cfg_code,
  input  logic                           dout_we,
  input  logic [NUM_PINS-1:0]            dout_data,
  input  logic                           ctrl_we,
  input  logic                           ctrl_regen,
  input  logic                           ctrl_dbg_dis,
  output logic [NUM_PINS-1:0][MODE_W-1:0] cfg_q,
  output logic [NUM_PINS-1:0]            dout_q,
  output logic                           regen_q,
  output logic                           dbgdis_q
);

  // R1, R12: reset values and write timing
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) cfg_q[i] <= MODE_IN_FLOAT;
      dout_q   <= '0;
      regen_q  <= 1'b1;
      dbgdis_q <= 1'b0;
    end else begin
      if (cfg_we && (32'(cfg_pin) < NUM_PINS)) cfg_q[cfg_pin] <= cfg_code;
      if (dout_we) dout_q <= dout_data;
      if (ctrl_we) begin
        regen_q  <= ctrl_regen;
        dbgdis_q <= ctrl_dbg_dis;
      end
    end
  end

endmodule

// File: rtl/pad_timer_route.sv
module pad_timer_route
  import pad_mux_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PPP = 8,
  parameter int NUM_CH = 4,
  parameter int PIN_W = 5
) (
  input  logic [NUM_CH-1:0]   ch_out,
  input  logic [NUM_CH-1:0]   ch_en,
  input  logic [NUM_CH-1:0]   remap,
  output logic [NUM_PINS-1:0] hit,
  output logic [NUM_PINS-1:0] val
);

  logic [NUM_CH-1:0][PIN_W-1:0] ch_pin;

  // R7: per-channel pin location
  for (genvar c = 0; c < NUM_CH; c++) begin : g_loc
    localparam int HOME = pin_of(PORT_A, tmr_home_bit(c), PPP);
    localparam int ALT = pin_of(PORT_B, tmr_alt_bit(c), PPP);
    assign ch_pin[c] = remap[c] ? PIN_W'(ALT) : PIN_W'(HOME);
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_comb begin
      hit[p] = 1'b0;
      val[p] = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_en[c] && (ch_pin[c] == PIN_W'(p))) begin
          hit[p] = 1'b1;
          val[p] = ch_out[c];
        end
      end
    end
  end

endmodule

// File: rtl/pad_pin_decode.sv
module pad_pin_decode
  import pad_mux_pkg::*;
(
  input  logic [MODE_W-1:0] code,
  input  logic              gpio_bit,
  input  logic              alt_bit,
  output pad_ctl_t          ctl
);

  // R2, R3, R4: mode decoding
  always_comb begin
    case (code)
      MODE_GPIO_PP: ctl = '{oe: 1'b1, out: gpio_bit, od: 1'b0, pu: 1'b0};
      MODE_GPIO_OD: ctl = '{oe: 1'b1, out: gpio_bit, od: 1'b1, pu: 1'b0};
      MODE_IN_PULL: ctl = PAD_PULLED;
      MODE_ALT_PP,
      MODE_ALT_CLK: ctl = '{oe: 1'b1, out: alt_bit, od: 1'b0, pu: 1'b0};
      MODE_ALT_OD:  ctl = '{oe: 1'b1, out: alt_bit, od: 1'b1, pu: 1'b0};
      default:      ctl = PAD_FLOAT;
    endcase
  end

endmodule

// File: rtl/pad_force.sv
module pad_force
  import pad_mux_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PPP = 8
) (
  input  pad_ctl_t [NUM_PINS-1:0] base,
  input  logic                    regen,
  input  logic                    dbgdis,
  input  logic                    reg_en_sig,
  input  logic                    dbg_active,
  input  logic                    dbg_swd,
  input  logic                    dbg_tdo,
  input  logic                    swdio_oe,
  input  logic                    swdio_out,
  output pad_ctl_t [NUM_PINS-1:0] final_ctl
);

  localparam int IDX_REG = pin_of(PORT_A, 7, PPP);
  localparam int IDX_RST = pin_of(PORT_C, 0, PPP);
  localparam int IDX_TDO = pin_of(PORT_C, 2, PPP);
  localparam int IDX_TDI = pin_of(PORT_C, 3, PPP);
  localparam int IDX_TMS = pin_of(PORT_C, 4, PPP);

  logic jtag_on, sw_on;

  assign jtag_on = dbg_active && !dbgdis && !dbg_swd;
  assign sw_on = dbg_active && !dbgdis && dbg_swd;

  always_comb begin
    final_ctl = base;
    // R8: regulator enable on A7
    if (regen) final_ctl[IDX_REG] = '{oe: 1'b1, out: reg_en_sig, od: 1'b1, pu: 1'b0};
    // R9: JTAG pins
    if (jtag_on) begin
      final_ctl[IDX_RST] = PAD_PULLED;
      final_ctl[IDX_TDI] = PAD_PULLED;
      final_ctl[IDX_TMS] = PAD_PULLED;
      final_ctl[IDX_TDO] = '{oe: 1'b1, out: dbg_tdo, od: 1'b0, pu: 1'b0};
    end
    // R10: serial-wire data pin
    if (sw_on) final_ctl[IDX_TMS] = '{oe: swdio_oe, out: swdio_out, od: 1'b0, pu: 1'b0};
  end

endmodule

// File: rtl/pad_func_mux.sv
module pad_func_mux
  import pad_mux_pkg::*;
#(
  parameter int PPP = 8,
  parameter int NUM_PORTS = 3,
  parameter int NUM_CH = 4,
  localparam int NUM_PINS = PPP * NUM_PORTS,
  localparam int PIN_W = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [PIN_W-1:0]    cfg_pin,
  input  logic [MODE_W-1:0]   cfg_code,
  input  logic                dout_we,
  input  logic [NUM_PINS-1:0] dout_data,
  input  logic                ctrl_we,
  input  logic                ctrl_regen,
  input  logic                ctrl_dbg_dis,
  input  logic [NUM_CH-1:0]   tmr_ch_out,
  input  logic [NUM_CH-1:0]   tmr_ch_en,
  input  logic [NUM_CH-1:0]   tmr_remap,
  input  logic [NUM_PINS-1:0] ser_out,
  input  logic [NUM_PINS-1:0] ser_valid,
  input  logic                reg_en_sig,
  input  logic                dbg_active,
  input  logic                dbg_swd,
  input  logic                dbg_tdo,
  input  logic                dbg_swdio_oe,
  input  logic                dbg_swdio_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_od,
  output logic [NUM_PINS-1:0] pad_pu
);

  logic [NUM_PINS-1:0][MODE_W-1:0] cfg_q;
  logic [NUM_PINS-1:0]             dout_q;
  logic                            regen_q;
  logic                            dbgdis_q;
  logic [NUM_PINS-1:0]             t_hit, t_val, alt_val;
  pad_ctl_t [NUM_PINS-1:0]         base_ctl, final_ctl;

  pad_cfg_regs #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_pin      (cfg_pin),
    .cfg_code     (cfg_code),
    .dout_we      (dout_we),
    .dout_data    (dout_data),
    .ctrl_we      (ctrl_we),
    .ctrl_regen   (ctrl_regen),
    .ctrl_dbg_dis (ctrl_dbg_dis),
    .cfg_q        (cfg_q),
    .dout_q       (dout_q),
    .regen_q      (regen_q),
    .dbgdis_q     (dbgdis_q)
  );

  pad_timer_route #(.NUM_PINS(NUM_PINS), .PPP(PPP), .NUM_CH(NUM_CH), .PIN_W(PIN_W)) u_route (
    .ch_out (tmr_ch_out),
    .ch_en  (tmr_ch_en),
    .remap  (tmr_remap),
    .hit    (t_hit),
    .val    (t_val)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    // R5, R6: timer beats serial, no source gives 0
    assign alt_val[p] = t_hit[p] ? t_val[p] : (ser_valid[p] & ser_out[p]);

    pad_pin_decode u_dec (
      .code     (cfg_q[p]),
      .gpio_bit (dout_q[p]),
      .alt_bit  (alt_val[p]),
      .ctl      (base_ctl[p])
    );

    assign pad_oe[p] = final_ctl[p].oe;
    assign pad_out[p] = final_ctl[p].out;
    assign pad_od[p] = final_ctl[p].od;
    assign pad_pu[p] = final_ctl[p].pu;
  end

  pad_force #(.NUM_PINS(NUM_PINS), .PPP(PPP)) u_force (
    .base       (base_ctl),
    .regen      (regen_q),
    .dbgdis     (dbgdis_q),
    .reg_en_sig (reg_en_sig),
    .dbg_active (dbg_active),
    .dbg_swd    (dbg_swd),
    .dbg_tdo    (dbg_tdo),
    .swdio_oe   (dbg_swdio_oe),
    .swdio_out  (dbg_swdio_out),
    .final_ctl  (final_ctl)
  );

endmodule

// File: rtl/pad_func_mux_chk.sv
module pad_func_mux_chk
  import pad_mux_pkg::*;
#(
  parameter int PPP = 8,
  parameter int NUM_PINS = 24,
  parameter int NUM_CH = 4,
  parameter int PIN_W = 5
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            cfg_we,
  input logic [PIN_W-1:0]                cfg_pin,
  input logic [MODE_W-1:0]               cfg_code,
  input logic [NUM_CH-1:0]               tmr_ch_out,
  input logic [NUM_CH-1:0]               tmr_ch_en,
  input logic [NUM_CH-1:0]               tmr_remap,
  input logic                            reg_en_sig,
  input logic                            dbg_active,
  input logic                            dbg_swd,
  input logic                            dbg_tdo,
  input logic [NUM_PINS-1:0][MODE_W-1:0] cfg_q,
  input logic                            regen_q,
  input logic                            dbgdis_q,
  input logic [NUM_PINS-1:0]             pad_oe,
  input logic [NUM_PINS-1:0]             pad_out,
  input logic [NUM_PINS-1:0]             pad_od,
  input logic [NUM_PINS-1:0]             pad_pu
);

  localparam int I_A0 = pin_of(PORT_A, 0, PPP);
  localparam int I_A7 = pin_of(PORT_A, 7, PPP);
  localparam int I_C0 = pin_of(PORT_C, 0, PPP);
  localparam int I_C2 = pin_of(PORT_C, 2, PPP);

  a_r1_reset_ctrl: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regen_q && !dbgdis_q));

  a_r12_cfg_write: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_pin == PIN_W'(I_A0)) |=> (cfg_q[I_A0] == $past(cfg_code)));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    a_r4_od_no_pull: assert property (@(posedge clk) disable iff (rst)
      !(pad_od[p] && pad_pu[p]));
    a_r2_drive_no_pull: assert property (@(posedge clk) disable iff (rst)
      !(pad_oe[p] && pad_pu[p]));
  end

  a_r8_regen_a7: assert property (@(posedge clk) disable iff (rst)
    regen_q |-> (pad_oe[I_A7] && pad_od[I_A7] && pad_out[I_A7] == reg_en_sig));

  a_r9_jtag_pins: assert property (@(posedge clk) disable iff (rst)
    (dbg_active && !dbg_swd && !dbgdis_q) |->
      (pad_oe[I_C2] && !pad_od[I_C2] && pad_out[I_C2] == dbg_tdo &&
       !pad_oe[I_C0] && pad_pu[I_C0]));

  a_r6_timer_wins: assert property (@(posedge clk) disable iff (rst)
    (tmr_ch_en[0] && !tmr_remap[0] && cfg_q[I_A0] == MODE_ALT_PP) |->
      (pad_out[I_A0] == tmr_ch_out[0]));

endmodule

bind pad_func_mux pad_func_mux_chk #(
  .PPP(PPP), .NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH), .PIN_W(PIN_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_pin    (cfg_pin),
  .cfg_code   (cfg_code),
  .tmr_ch_out (tmr_ch_out),
  .tmr_ch_en  (tmr_ch_en),
  .tmr_remap  (tmr_remap),
  .reg_en_sig (reg_en_sig),
  .dbg_active (dbg_active),
  .dbg_swd    (dbg_swd),
  .dbg_tdo    (dbg_tdo),
  .cfg_q      (cfg_q),
  .regen_q    (regen_q),
  .dbgdis_q   (dbgdis_q),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .pad_od     (pad_od),
  .pad_pu     (pad_pu)
);

// File: tb/test_pad_func_mux.sv
module test_pad_func_mux;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int PW = 5;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [PW-1:0] cfg_pin = '0;
  logic [3:0] cfg_code = '0;
  logic dout_we = 1'b0;
  logic [NP-1:0] dout_data = '0;
  logic ctrl_we = 1'b0, ctrl_regen = 1'b0, ctrl_dbg_dis = 1'b0;
  logic [NCH-1:0] tmr_ch_out = '0, tmr_ch_en = '0, tmr_remap = '0;
  logic [NP-1:0] ser_out = '0, ser_valid = '0;
  logic reg_en_sig = 1'b1;
  logic dbg_active = 1'b0, dbg_swd = 1'b0, dbg_tdo = 1'b0;
  logic dbg_swdio_oe = 1'b0, dbg_swdio_out = 1'b0;
  logic [NP-1:0] pad_oe, pad_out, pad_od, pad_pu;

  int checks = 0;
  int errors = 0;

  pad_func_mux i_pad_func_mux (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_code(cfg_code),
    .dout_we(dout_we), .dout_data(dout_data), .ctrl_we(ctrl_we),
    .ctrl_regen(ctrl_regen), .ctrl_dbg_dis(ctrl_dbg_dis),
    .tmr_ch_out(tmr_ch_out), .tmr_ch_en(tmr_ch_en), .tmr_remap(tmr_remap),
    .ser_out(ser_out), .ser_valid(ser_valid), .reg_en_sig(reg_en_sig),
    .dbg_active(dbg_active), .dbg_swd(dbg_swd), .dbg_tdo(dbg_tdo),
    .dbg_swdio_oe(dbg_swdio_oe), .dbg_swdio_out(dbg_swdio_out),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_od(pad_od), .pad_pu(pad_pu)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {oe,out,od,pu}
  typedef struct packed {
    logic [3:0] code;
    logic       dbit;
    logic       sv;
    logic       so;
    logic       te;
    logic       tv;
    logic [3:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{4'h4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 4'd2},  // R2 floating
    '{4'h1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1100, 4'd2},  // R2 push-pull 1
    '{4'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000, 4'd2},  // R2 push-pull 0
    '{4'h5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1010, 4'd2},  // R2 open-drain
    '{4'h8, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'd2},  // R2 pull-up
    '{4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 4'd3},  // R3 code 0
    '{4'hF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'b0000, 4'd3},  // R3 code F
    '{4'h2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 4'd3},  // R3 code 2
    '{4'h9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd4},  // R4 alt pp
    '{4'hD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1010, 4'd4},  // R4 alt od
    '{4'hB, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd4},  // R4 clock pp
    '{4'h9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1000, 4'd5},  // R5 no source
    '{4'h9, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b1100, 4'd6},  // R6 timer over serial
    '{4'hD, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'b1010, 4'd6},  // R6 timer 0 wins
    '{4'h9, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b1100, 4'd6}   // R6 timer off, serial
  };

  function automatic logic [3:0] pad(int p);
    return {pad_oe[p], pad_out[p], pad_od[p], pad_pu[p]};
  endfunction

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(int p, logic [3:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pin = PW'(p); cfg_code = c;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_dout(logic [NP-1:0] v);
    @(negedge clk);
    dout_we = 1'b1; dout_data = v;
    @(negedge clk);
    dout_we = 1'b0;
  endtask

  task automatic write_ctrl(logic regen, logic dis);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_regen = regen; ctrl_dbg_dis = dis;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state of all non-forced pins
    bad = 0;
    for (int p = 0; p < NP; p++) if (p != 7 && pad(p) != 4'b0000) bad++;
    check("R1", "pins not floating after reset", 4'(bad), 4'd0);
    // R8: regulator forced on A7 after reset
    check("R8", "A7 after reset", pad(7), 4'b1110);
    reg_en_sig = 1'b0; #1;
    check("R8", "A7 follows reg_en_sig", pad(7), 4'b1010);

    // Vector walk on pin A0, channel 1 at home location
    for (int i = 0; i < 15; i++) begin
      write_dout(NP'(VEC[i].dbit));
      ser_valid[0] = VEC[i].sv; ser_out[0] = VEC[i].so;
      tmr_ch_en[0] = VEC[i].te; tmr_ch_out[0] = VEC[i].tv;
      write_cfg(0, VEC[i].code);
      #1;
      check($sformatf("R%0d", VEC[i].req), $sformatf("vector %0d", i), pad(0), VEC[i].exp);
    end
    ser_valid = '0; ser_out = '0;

    // R7: timer channel routing
    write_cfg(9, 4'h9);
    tmr_ch_en = 4'b0001; tmr_ch_out = 4'b0001; tmr_remap = 4'b0000; #1;
    check("R7", "ch1 home A0", pad(0), 4'b1100);
    check("R7", "ch1 home leaves B1", pad(9), 4'b1000);
    tmr_remap = 4'b0001; #1;
    check("R7", "ch1 remap leaves A0", pad(0), 4'b1000);
    check("R7", "ch1 remap B1", pad(9), 4'b1100);
    write_cfg(12, 4'h9);
    tmr_ch_en = 4'b1000; tmr_ch_out = 4'b1000; tmr_remap = 4'b1000; #1;
    check("R7", "ch4 remap B4", pad(12), 4'b1100);
    tmr_remap = 4'b0000; #1;
    check("R7", "ch4 home leaves B4", pad(12), 4'b1000);
    write_cfg(1, 4'hD);
    tmr_ch_en = 4'b0100; tmr_ch_out = 4'b0100; #1;
    check("R7", "ch3 home A1", pad(1), 4'b1110);
    tmr_remap = 4'b0100; #1;
    check("R7", "ch3 remap leaves A1", pad(1), 4'b1010);
    tmr_ch_en = '0; tmr_ch_out = '0; tmr_remap = '0;

    // R8: regulator override and release
    write_dout(NP'(1) << 7);
    write_cfg(7, 4'h1);
    #1;
    check("R8", "A7 forced over mode", pad(7), 4'b1010);
    write_ctrl(1'b0, 1'b0);
    #1;
    check("R8", "A7 released to push-pull", pad(7), 4'b1100);

    // R9: JTAG forcing
    write_dout((NP'(1) << 16) | (NP'(1) << 7));
    write_cfg(16, 4'h1);
    write_cfg(18, 4'h8);
    dbg_active = 1'b1; dbg_swd = 1'b0; dbg_tdo = 1'b1; #1;
    check("R9", "C0 pulled input", pad(16), 4'b0001);
    check("R9", "C2 tdo", pad(18), 4'b1100);
    check("R9", "C3 pulled input", pad(19), 4'b0001);
    check("R9", "C4 pulled input", pad(20), 4'b0001);
    dbg_tdo = 1'b0; #1;
    check("R9", "C2 tdo low", pad(18), 4'b1000);

    // R10: serial-wire mode
    dbg_swd = 1'b1; dbg_swdio_oe = 1'b1; dbg_swdio_out = 1'b1; #1;
    check("R10", "C4 driven", pad(20), 4'b1100);
    dbg_swdio_oe = 1'b0; #1;
    check("R10", "C4 released", pad(20), 4'b0100);
    check("R10", "C0 follows mode", pad(16), 4'b1100);
    check("R10", "C2 follows mode", pad(18), 4'b0001);

    // R11: debug disable
    dbg_swd = 1'b0;
    write_ctrl(1'b0, 1'b1);
    #1;
    check("R11", "C0 follows mode", pad(16), 4'b1100);
    check("R11", "C2 follows mode", pad(18), 4'b0001);
    check("R11", "C4 follows mode", pad(20), 4'b0000);

    // R12: write timing
    write_dout(NP'(1) << 3);
    @(negedge clk);
    cfg_we = 1'b1; cfg_pin = PW'(3); cfg_code = 4'h1; #1;
    check("R12", "A3 before edge", pad(3), 4'b0000);
    @(negedge clk);
    cfg_we = 1'b0; #1;
    check("R12", "A3 after edge", pad(3), 4'b1100);

    // R1: reset mid-run restores defaults
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; #1;
    check("R1", "A3 floating again", pad(3), 4'b0000);
    check("R1", "debug-disable cleared, C2 forced", pad(18), 4'b1000);
    check("R1", "regen set again", pad(7), 4'b1010);
    check("R1", "C0 forced again", pad(16), 4'b0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule